// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the digital side of a low-power successive-approximation converter so that a host controller can be tested against it. The host lowers an active-low select, then toggles a serial clock; the block answers on one data line, with a separate enable that marks when the line would be driven rather than left floating. A parallel word supplies the conversion result that the block pretends to have measured.

Both host signals are brought into the system clock domain through a synchronizer and edge detector. A frame begins on a falling select. Two sampling clocks follow, with the line floating. Then comes a low null bit and the result, most significant bit first. If the host keeps clocking, the remaining bits are sent again in reverse order and after that only zeros. Raising the select floats the line and parks the block in full power-down. A phase output tells which part of the frame is being sent.

Top module: `sar_serial_emu`

## Requirements
- R1: After reset the phase output is 0 (power-down), the output enable is 0 and the data line is 0.
- R2: A falling select latches the sample word and enters phase 1 (sampling). The output enable stays 0 through the first falling serial clock edge of the frame.
- R3: The second falling serial clock edge of a frame sets the output enable to 1 and drives a 0 null bit, in phase 2.
- R4: The next RES_BITS falling edges present the latched word, bit RES_BITS-1 first down to bit 0, in phase 3. The line changes only on falling serial clock edges and holds its value across each rising edge.
- R5: Each falling edge after bit 0 presents bits 1, 2, ... RES_BITS-1 of the word in that order, in phase 4. Bit 0 is not repeated.
- R6: After bit RES_BITS-1 of the replay, every further falling edge drives 0 with the enable held at 1, in phase 5, for as long as clocking continues.
- R7: A rising select at any point of a frame returns the block to phase 0 with the enable at 0 and the data line at 0.
- R8: Changes to the sample word after the select has fallen do not alter the bits sent in that frame.
- R9: While the select is high, serial clock edges and sample word changes leave the phase at 0, the enable at 0 and the line at 0.
- R10: The word is sent as straight binary with no recoding: a zero word gives all 0 bits, a word with only bit RES_BITS-1 set gives a single 1 first, and an all-ones word gives all 1 bits.
- R11: A new frame starts only on a high-to-low transition of the select; the phase codes are 0 power-down, 1 sampling, 2 null bit, 3 MSB-first word, 4 replay, 5 zero fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample_word | input | RES_BITS | Result word to be sent, straight binary |
| sdo | output | 1 | Serial data line, 0 while disabled |
| sdo_oe | output | 1 | 1 when the data line would be driven, 0 for high impedance |
| phase | output | 3 | Current frame phase code |

## Verification
Every output is registered and responds SYNC_STAGES+1 system cycles after a change on the select or the serial clock: SYNC_STAGES cycles to pass the synchronizer and one more for the registers fed by the edge detector. With the default of two stages that is three cycles. The bench holds every select and serial clock level for six system cycles and samples all outputs on a falling system clock edge at the end of each hold, so each check lands after the response is due and before the next input change. Checks after a rising serial clock confirm that nothing moved, and checks after a falling edge compare against the bit the frame position predicts.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;

  typedef enum logic [2:0] {
    PH_PDOWN  = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_NULL   = 3'd2,
    PH_MSB    = 3'd3,
    PH_REPLAY = 3'd4,
    PH_ZERO   = 3'd5
  } phase_t;

  function automatic logic phase_drives(input phase_t p);
    return (p == PH_NULL) || (p == PH_MSB) || (p == PH_REPLAY) || (p == PH_ZERO);
  endfunction

  function automatic logic phase_carries_data(input phase_t p);
    return (p == PH_MSB) || (p == PH_REPLAY);
  endfunction

endpackage

// File: rtl/sar_emu_sync.sv
module sar_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sclk_in,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall
);

  logic cs_s, sclk_s;
  logic cs_prev, sclk_prev;

  generate
    if (STAGES <= 1) begin : g_single
      logic cs_r, sclk_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_r   <= 1'b1;
          sclk_r <= 1'b0;
        end else begin
          cs_r   <= cs_n_in;
          sclk_r <= sclk_in;
        end
      end
      assign cs_s   = cs_r;
      assign sclk_s = sclk_r;
    end else begin : g_chain
      logic [STAGES-1:0] cs_chain, sclk_chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_chain   <= '1;
          sclk_chain <= '0;
        end else begin
          cs_chain   <= {cs_chain[STAGES-2:0], cs_n_in};
          sclk_chain <= {sclk_chain[STAGES-2:0], sclk_in};
        end
      end
      assign cs_s   = cs_chain[STAGES-1];
      assign sclk_s = sclk_chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end

  assign cs_fall   = cs_prev & ~cs_s;
  assign cs_rise   = ~cs_prev & cs_s;
  assign sclk_fall = sclk_prev & ~sclk_s;

  AST_SELECT_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_fall, cs_rise})); // R11

  AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> !cs_fall); // R11

endmodule

// File: rtl/sar_emu_frame.sv
module sar_emu_frame
  import sar_emu_pkg::*;
#(
  parameter int RES_BITS = 12,
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  output phase_t           phase_q,
  output phase_t           phase_d,
  output logic [IDX_W-1:0] idx_d
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);
  localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;
  logic             smp_seen_q, smp_seen_d;

  always_comb begin
    phase_d    = phase_q;
    idx_d      = idx_q;
    smp_seen_d = smp_seen_q;
    if (cs_rise) begin
      phase_d    = PH_PDOWN;
      idx_d      = '0;
      smp_seen_d = 1'b0;
    end else if (cs_fall) begin
      phase_d    = PH_SAMPLE;
      idx_d      = '0;
      smp_seen_d = 1'b0;
    end else if (sclk_fall) begin
      unique case (phase_q)
        PH_SAMPLE: begin
          if (smp_seen_q) phase_d = PH_NULL;
          else            smp_seen_d = 1'b1;
        end
        PH_NULL: begin
          phase_d = PH_MSB;
          idx_d   = TOP_IDX;
        end
        PH_MSB: begin
          if (idx_q == '0) begin
            phase_d = PH_REPLAY;
            idx_d   = ONE_IDX;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
        PH_REPLAY: begin
          if (idx_q == TOP_IDX) begin
            phase_d = PH_ZERO;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_PDOWN;
      idx_q      <= '0;
      smp_seen_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      idx_q      <= idx_d;
      smp_seen_q <= smp_seen_d;
    end
  end

  AST_INDEX_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    idx_q <= TOP_IDX); // R4

  AST_RISE_TO_PDOWN: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (phase_q == PH_PDOWN)); // R7

  AST_PDOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PDOWN && !cs_fall) |=> (phase_q == PH_PDOWN)); // R9

  AST_NULL_THEN_MSB: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NULL && sclk_fall && !cs_rise && !cs_fall)
      |=> (phase_q == PH_MSB && idx_q == TOP_IDX)); // R4

  AST_REPLAY_SKIPS_LSB: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q == PH_REPLAY) |-> (idx_q == ONE_IDX)); // R5

  AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ZERO && !cs_rise) |=> (phase_q == PH_ZERO)); // R6

endmodule

// File: rtl/sar_emu_shift.sv
module sar_emu_shift
  import sar_emu_pkg::*;
#(
  parameter int RES_BITS = 12,
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_fall,
  input  logic [RES_BITS-1:0] sample_word,
  input  phase_t              phase_d,
  input  logic [IDX_W-1:0]    idx_d,
  output logic                sdo,
  output logic                sdo_oe
);

  logic [RES_BITS-1:0] word_q;
  logic                sdo_d, oe_d;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (cs_fall) word_q <= sample_word;
  end

  always_comb begin
    oe_d  = phase_drives(phase_d);
    sdo_d = 1'b0;
    if (phase_carries_data(phase_d)) sdo_d = word_q[idx_d];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo    <= sdo_d;
      sdo_oe <= oe_d;
    end
  end

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cs_fall |=> $stable(word_q)); // R8

  AST_LINE_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo); // R7

endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu
  import sar_emu_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample_word,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [2:0]          phase
);

  logic             cs_fall, cs_rise, sclk_fall;
  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] idx_d;

  sar_emu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cs_n_in   (cs_n),
    .sclk_in   (sclk),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall)
  );

  sar_emu_frame #(.RES_BITS(RES_BITS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .idx_d     (idx_d)
  );

  sar_emu_shift #(.RES_BITS(RES_BITS)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .cs_fall     (cs_fall),
    .sample_word (sample_word),
    .phase_d     (phase_d),
    .idx_d       (idx_d),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  assign phase = phase_q;

  AST_QUIET_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PDOWN || phase_q == PH_SAMPLE) |-> !sdo_oe); // R2

  AST_DRIVEN_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NULL || phase_q == PH_ZERO) |-> (sdo_oe && !sdo)); // R3

endmodule

// File: tb/tb_sar_serial_emu.sv
module tb_sar_serial_emu;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 12;
  localparam int HOLD       = 6;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [N-1:0] sample_word = '0;
  logic         sdo, sdo_oe;
  logic [2:0]   phase;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_emu #(.RES_BITS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .sample_word(sample_word), .sdo(sdo), .sdo_oe(sdo_oe), .phase(phase)
  );

  // {phase, oe, sdo} expected after k falling serial edges of a frame
  function automatic logic [4:0] expect_at(logic [N-1:0] w, int k);
    if (k <= 1)            return {3'd1, 1'b0, 1'b0};
    if (k == 2)            return {3'd2, 1'b1, 1'b0};
    if (k <= N + 2)        return {3'd3, 1'b1, w[N + 2 - k]};
    if (k <= 2 * N + 1)    return {3'd4, 1'b1, w[k - N - 2]};
    return {3'd5, 1'b1, 1'b0};
  endfunction

  function automatic string tag_at(int k);
    if (k <= 1)         return "R2";
    if (k == 2)         return "R3/R11";
    if (k <= N + 2)     return "R4";
    if (k <= 2 * N + 1) return "R5";
    return "R6";
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {phase, sdo_oe, sdo};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got phase=%0d oe=%0b sdo=%0b expected phase=%0d oe=%0b sdo=%0b",
               req, got[4:2], got[1], got[0], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic run_frame(logic [N-1:0] w, int nfall, bit late_change, string force_tag);
    string t;
    @(negedge clk);
    sample_word = w;
    cs_n = 1'b0;
    hold();
    chk("R2", expect_at(w, 0));
    if (late_change) sample_word = ~w;
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b1;
      hold();
      chk("R4 rise-hold", expect_at(w, k - 1));
      if (late_change && k == 3) sample_word = w ^ N'(12'h5A5);
      sclk = 1'b0;
      hold();
      t = (force_tag != "") ? force_tag : (late_change ? "R8" : tag_at(k));
      chk(t, expect_at(w, k));
    end
    cs_n = 1'b1;
    hold();
    chk("R7", 5'b000_0_0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    hold();
    chk("R1", 5'b000_0_0);

    // R9: clocks and word changes while deselected
    for (int i = 0; i < 3; i++) begin
      sample_word = N'($urandom);
      sclk = 1'b1; hold(); chk("R9", 5'b000_0_0);
      sclk = 1'b0; hold(); chk("R9", 5'b000_0_0);
    end

    // R10: straight binary corner words, full frame into zero fill
    run_frame('0, 2 * N + 4, 1'b0, "R10");
    run_frame(N'(1) << (N - 1), 2 * N + 4, 1'b0, "R10");
    run_frame('1, 2 * N + 4, 1'b0, "R10");

    // full frames with distinct patterns
    run_frame(N'(12'hA5C), 2 * N + 5, 1'b0, "");
    run_frame(N'(12'h3C1), 2 * N + 3, 1'b0, "");

    // R8: word changes after select falls
    run_frame(N'(12'h6B2), 2 * N + 3, 1'b1, "");

    // R7 / R11: aborts at various points, then a fresh frame
    run_frame(N'(12'h0F0), 1, 1'b0, "");
    run_frame(N'(12'h0F0), 5, 1'b0, "");
    run_frame(N'(12'h871), N + 4, 1'b0, "");

    // constrained random frames
    void'($urandom(32'd1234));
    for (int i = 0; i < 20; i++) begin
      logic [N-1:0] w;
      int nf;
      w  = N'($urandom);
      nf = 1 + ($urandom % (2 * N + 6));
      run_frame(w, nf, ($urandom % 4) == 0, "");
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule